// File: doc/BRIEF.md
# Cache Valid-Array Invalidation Controller

This block holds the control register of a small direct-mapped cache and keeps the cache's per-set valid bits. Software writes one 32-bit word to turn the cache on or off, to freeze its contents, and to request that every line be invalidated. The tag and data arrays sit elsewhere. This block only answers, for the set being looked up, whether a valid line exists there. For a completed line fill, it also decides whether that fill may be written into its target set.

An invalidate-all request starts a sweep that clears one set per clock, starting at set 0 and ending at the last set. While the sweep runs, the access side is stalled. When the sweep ends, the request bit clears by itself. Turning the cache off, or applying reset, leaves the valid bits untouched. Freeze lets fills land only in sets that are not yet valid.

Top module: `cache_inval_ctl`

## Requirements
- R1: After reset the control register reads 0x0000_0000 and `acc_stall` is low.
- R2: The control word has enable at bit 31, freeze at bit 27 and invalidate-all at bit 24. Every other bit reads as zero, whatever value is written to it.
- R3: A write with bit 24 set starts a sweep. A write with bit 24 clear starts nothing.
- R4: A sweep keeps `acc_stall` high for exactly 64 cycles. During those cycles bit 24 reads as 1, and afterwards it reads as 0 with no software action.
- R5: After a sweep, `lk_valid` is 0 for every set.
- R6: While a sweep runs, `lk_valid` is 0 and `fill_wr` is 0 for any request.
- R7: A write with bit 24 set while a sweep is running is ignored. The sweep neither restarts nor lengthens.
- R8: With enable clear, `lk_valid` and `fill_wr` are 0 and the valid bits are retained. After enable is set again, earlier valid sets report valid once more.
- R9: With freeze set, a fill to a valid set is refused (`fill_wr`=0). A fill to an invalid set is accepted and makes that set valid.
- R10: With enable set, freeze clear and no sweep running, every fill is accepted, and its set reads valid from the next cycle.
- R11: Reset does not clear the valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| lk_set | input | 6 | Set index being looked up |
| lk_valid | output | 1 | Looked-up set holds a usable valid line |
| acc_stall | output | 1 | Access side must wait (sweep running) |
| fill_req | input | 1 | A line fill has completed and asks to be written |
| fill_set | input | 6 | Target set of the fill |
| fill_wr | output | 1 | Fill granted; the set becomes valid |

## Verification
On every cycle the assertions check several properties. The sweep counter steps by exactly one set per clock, and the sweep ends only at the last set. A sweep starts only from a write with bit 24 set, and a repeated request does not disturb a running sweep. Lookups and fills are held off while the stall is high, and a fill never overwrites a valid set under freeze. Reserved read bits are zero, and a granted fill leaves its set valid. Other behaviours depend on a history that the bench's directed scenarios build up: valid bits surviving a disabled period and a reset, the full 64-cycle stall length seen from the ports, and the all-invalid state after a sweep.

// File: rtl/cache_inval_ctl.sv
module cache_inval_ctl #(
  parameter int SETS  = 64,
  parameter int REG_W = 32,
  parameter int EN_B  = 31,
  parameter int FRZ_B = 27,
  parameter int INV_B = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [REG_W-1:0]         cfg_wdata,
  output logic [REG_W-1:0]         cfg_rdata,
  input  logic [$clog2(SETS)-1:0]  lk_set,
  output logic                     lk_valid,
  output logic                     acc_stall,
  input  logic                     fill_req,
  input  logic [$clog2(SETS)-1:0]  fill_set,
  output logic                     fill_wr
);
  localparam int CNT_W = $clog2(SETS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETS - 1);
  localparam logic [REG_W-1:0] RSV_MASK =
    ~((REG_W'(1) << EN_B) | (REG_W'(1) << FRZ_B) | (REG_W'(1) << INV_B));

  logic             en_q, frz_q, busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             v_q [SETS];
  logic             start;

  assign start = cfg_we & cfg_wdata[INV_B] & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      frz_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (cfg_we) begin
        en_q  <= cfg_wdata[EN_B];
        frz_q <= cfg_wdata[FRZ_B];
      end
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q)       v_q[cnt_q]    <= 1'b0;
    else if (fill_wr) v_q[fill_set] <= 1'b1;
  end

  assign acc_stall = busy_q;
  assign lk_valid  = en_q & ~busy_q & v_q[lk_set];
  assign fill_wr   = fill_req & en_q & ~busy_q & (~frz_q | ~v_q[fill_set]);

  always_comb begin
    cfg_rdata        = '0;
    cfg_rdata[EN_B]  = en_q;
    cfg_rdata[FRZ_B] = frz_q;
    cfg_rdata[INV_B] = busy_q;
  end

  always_comb begin
    a_rsv_zero_r2: assert ((cfg_rdata & RSV_MASK) == '0);
  end

  p_start_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cfg_we && cfg_wdata[INV_B]) && cnt_q == '0);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cnt_q != LAST |=> busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cnt_q == LAST |=> !busy_q);

  p_noreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !(cfg_we && cfg_wdata[INV_B]) |=> !busy_q);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stall |-> !lk_valid && !fill_wr);

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cfg_we && cfg_wdata[INV_B] && cnt_q != LAST |=> cnt_q != '0);

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[EN_B] |-> !lk_valid && !fill_wr);

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && frz_q && v_q[fill_set] |-> !fill_wr);

  p_fill_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr |=> v_q[$past(fill_set)]);
endmodule

// File: tb/sim_cache_inval_ctl.sv
module sim_cache_inval_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [5:0]  lk_set = '0;
  logic        lk_valid;
  logic        acc_stall;
  logic        fill_req = 1'b0;
  logic [5:0]  fill_set = '0;
  logic        fill_wr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cache_inval_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lk_set(lk_set), .lk_valid(lk_valid),
    .acc_stall(acc_stall), .fill_req(fill_req), .fill_set(fill_set),
    .fill_wr(fill_wr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic look(input logic [5:0] s, input bit exp, input string req);
    lk_set = s; #1;
    chk(lk_valid == exp, req, 32'(lk_valid), 32'(exp));
  endtask

  task automatic fill(input logic [5:0] s, input bit exp, input string req);
    @(negedge clk);
    fill_req = 1'b1; fill_set = s; #1;
    chk(fill_wr == exp, req, 32'(fill_wr), 32'(exp));
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(cfg_rdata == 32'h0, "R1 rdata", cfg_rdata, 32'h0);
    chk(acc_stall == 1'b0, "R1 stall", 32'(acc_stall), 32'h0);
  endtask

  task automatic t_sweep();
    int n = 0;
    wr(32'h8100_0000);
    chk(cfg_rdata[24] == 1'b1, "R4 busy bit", cfg_rdata, 32'h8100_0000);
    while (acc_stall && n < 200) begin n++; @(negedge clk); end
    chk(n == 64, "R4 stall length", n, 64);
    chk(cfg_rdata == 32'h8000_0000, "R4 self clear", cfg_rdata, 32'h8000_0000);
    begin
      int bad = 0;
      for (int s = 0; s < 64; s++) begin
        lk_set = 6'(s); #1;
        if (lk_valid) bad++;
      end
      chk(bad == 0, "R5 all invalid", bad, 0);
    end
  endtask

  task automatic t_noinv();
    wr(32'h8000_0000);
    chk(acc_stall == 1'b0, "R3 zero write", 32'(acc_stall), 32'h0);
    @(negedge clk);
    chk(acc_stall == 1'b0, "R3 zero write later", 32'(acc_stall), 32'h0);
  endtask

  task automatic t_plain_fill();
    fill(6'd5, 1'b1, "R10 fill accepted");
    look(6'd5, 1'b1, "R10 set valid");
    fill(6'd5, 1'b1, "R10 overwrite accepted");
  endtask

  task automatic t_freeze();
    wr(32'h8800_0000);
    fill(6'd5, 1'b0, "R9 valid set refused");
    fill(6'd9, 1'b1, "R9 invalid set accepted");
    look(6'd9, 1'b1, "R9 set now valid");
    fill(6'd9, 1'b0, "R9 now refused");
  endtask

  task automatic t_reserved();
    wr(32'h7EFF_FFFF);
    chk(cfg_rdata == 32'h0800_0000, "R2 reserved zero", cfg_rdata, 32'h0800_0000);
    chk(acc_stall == 1'b0, "R2 no sweep", 32'(acc_stall), 32'h0);
  endtask

  task automatic t_disable();
    wr(32'h0000_0000);
    look(6'd5, 1'b0, "R8 off miss");
    fill(6'd12, 1'b0, "R8 off fill refused");
    wr(32'h8000_0000);
    look(6'd5, 1'b1, "R8 retained 5");
    look(6'd9, 1'b1, "R8 retained 9");
    look(6'd12, 1'b0, "R8 no fill 12");
  endtask

  task automatic t_reset_keeps();
    t_reset();
    wr(32'h8000_0000);
    look(6'd5, 1'b1, "R11 valid after reset");
  endtask

  task automatic t_busy_ops();
    int n = 0;
    wr(32'h8100_0000);
    look(6'd5, 1'b0, "R6 lookup during sweep");
    fill_req = 1'b1; fill_set = 6'd20; #1;
    chk(fill_wr == 1'b0, "R6 fill during sweep", 32'(fill_wr), 32'h0);
    fill_req = 1'b0;
    while (acc_stall && n < 200) begin
      if (n == 10) begin cfg_we = 1'b1; cfg_wdata = 32'h8100_0000; end
      else begin cfg_we = 1'b0; cfg_wdata = '0; end
      n++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    chk(n == 64, "R7 sweep not restarted", n, 64);
    look(6'd5, 1'b0, "R5 cleared 5");
    look(6'd20, 1'b0, "R6 fill not taken");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_noinv();
    t_plain_fill();
    t_freeze();
    t_reserved();
    t_disable();
    t_reset_keeps();
    t_busy_ops();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule